// File: doc/BRIEF.md
# Bouncing Colour Squares Pixel Generator

This block colours the visible pixels for a small animated demo: three squares, one tinted red, one green and one blue, travel around a 640x480 visible region and rebound from its four borders. It sits behind an external raster counter that supplies the current column and row, a visible-region flag and the two sync lines. For each pixel clock it decides which squares cover the current coordinate and produces a 4-bit value per colour channel.

Every square has its own size, horizontal and vertical step, starting corner and starting heading, all set by parameters. The squares move only once per frame, on a single-cycle tick at the first pixel of the first blanking line, so a picture is never drawn with a square half moved. Where squares overlap, their primary colours add up: red and green give yellow, and all three give white. The colour channels and the delayed sync lines leave the block from one register stage, so they stay aligned with each other.

Top module: `bounce_squares`

## Requirements
- R1: While reset is high, all three colour outputs are 0 and both sync outputs are 1; reset loads every square's parameter start corner and heading, and the first frame after reset draws the squares there.
- R2: The frame tick is high only in a cycle where the row input equals V_RES (480) and the column input equals 0; square positions and headings change only in a cycle after such a tick and stay fixed for any other coordinate, including row 480 at column 1 and column 0 at rows 479 and 481.
- R3: Horizontal far-edge rule: on a tick, when x is at least H_RES - (size + x step), the heading becomes leftward (flag 1) and x drops by the step in the same update.
- R4: Horizontal near-edge rule: on a tick, when the far-edge rule does not apply and x is below the x step, the heading becomes rightward (flag 0) and x grows by the step in the same update.
- R5: On a tick with no edge rule applying, x moves by its step: down when the heading flag is 1, up when it is 0.
- R6: The vertical axis follows the rules of R3 to R5 on its own, with V_RES (480), the square's y step and its own heading flag (1 means upward).
- R7: A square covers pixel (sx, sy) when qx <= sx < qx + size and qy <= sy < qy + size, with (qx, qy) the square's top-left corner.
- R8: Square 0 drives red, square 1 green and square 2 blue; a covering square sets its own channel to 0xF, channels of overlapping squares combine independently, and an uncovered pixel is black (all channels 0).
- R9: When the visible-region flag is low, all three colour outputs are 0 one cycle later, whatever squares cover the coordinate.
- R10: The colour outputs and the sync outputs are registered in one stage: each output reflects the inputs of the previous clock cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| sx | input | CW (10) | Current column from the raster counter |
| sy | input | CW (10) | Current row from the raster counter |
| vis | input | 1 | High while the coordinate is inside the visible region |
| hs_in | input | 1 | Horizontal sync from the raster counter |
| vs_in | input | 1 | Vertical sync from the raster counter |
| hs_out | output | 1 | Horizontal sync delayed by one clock |
| vs_out | output | 1 | Vertical sync delayed by one clock |
| red | output | 4 | Red channel |
| green | output | 4 | Green channel |
| blue | output | 4 | Blue channel |

## Verification
The hardest cases to reach from the ports are the edge rebounds, because a square only reaches a border after many frame ticks and its position is visible only through the colour of probed pixels. The bench drives the tick coordinate directly, with no probes scanned in between, over several hundred frames so that every square meets all four borders. After each tick it probes the corners of each square and the pixels just outside it, labelled by the rule that moved the square last. The squares start out overlapping so that yellow, cyan and white regions are probed straight after reset.

// File: rtl/sq_pkg.sv
package sq_pkg;
  localparam int CHW   = 4;
  localparam int NSQ   = 3;
  typedef logic [CHW-1:0] chan_t;
  localparam chan_t CH_ON  = '1;
  localparam chan_t CH_OFF = '0;
endpackage

// File: rtl/sq_tick.sv
module sq_tick #(
  parameter int CW    = 10,
  parameter int V_RES = 480
) (
  input  logic [CW-1:0] sx,
  input  logic [CW-1:0] sy,
  output logic          tick
);
  always_comb tick = (sy == CW'(V_RES)) && (sx == '0);
endmodule

// File: rtl/sq_axis.sv
module sq_axis #(
  parameter int CW    = 10,
  parameter int RES   = 640,
  parameter int SIZE  = 32,
  parameter int STEP  = 4,
  parameter int START = 100,
  parameter bit DIR0  = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  output logic [CW-1:0] pos,
  output logic          dir
);
  localparam int FAR_LIM = RES - (SIZE + STEP);
  localparam logic [CW-1:0] FAR_C  = CW'(FAR_LIM);
  localparam logic [CW-1:0] STEP_C = CW'(STEP);

  always_ff @(posedge clk) begin
    if (rst) begin
      pos <= CW'(START);
      dir <= DIR0;
    end else if (tick) begin
      if (pos >= FAR_C) begin
        dir <= 1'b1;
        pos <= pos - STEP_C;
      end else if (pos < STEP_C) begin
        dir <= 1'b0;
        pos <= pos + STEP_C;
      end else if (dir) begin
        pos <= pos - STEP_C;
      end else begin
        pos <= pos + STEP_C;
      end
    end
  end
endmodule

// File: rtl/sq_cover.sv
module sq_cover #(
  parameter int CW   = 10,
  parameter int SIZE = 32
) (
  input  logic [CW-1:0] sx,
  input  logic [CW-1:0] sy,
  input  logic [CW-1:0] qx,
  input  logic [CW-1:0] qy,
  output logic          hit
);
  localparam logic [CW:0] SIZE_C = (CW+1)'(SIZE);
  logic [CW:0] x_end, y_end;
  always_comb begin
    x_end = {1'b0, qx} + SIZE_C;
    y_end = {1'b0, qy} + SIZE_C;
    hit   = (sx >= qx) && ({1'b0, sx} < x_end)
         && (sy >= qy) && ({1'b0, sy} < y_end);
  end
endmodule

// File: rtl/sq_out.sv
module sq_out
  import sq_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic           vis,
  input  logic           hs_in,
  input  logic           vs_in,
  input  logic [NSQ-1:0] hit,
  output logic           hs_out,
  output logic           vs_out,
  output chan_t          red,
  output chan_t          green,
  output chan_t          blue
);
  always_ff @(posedge clk) begin
    if (rst) begin
      hs_out <= 1'b1;
      vs_out <= 1'b1;
      red    <= CH_OFF;
      green  <= CH_OFF;
      blue   <= CH_OFF;
    end else begin
      hs_out <= hs_in;
      vs_out <= vs_in;
      red    <= (vis && hit[0]) ? CH_ON : CH_OFF;
      green  <= (vis && hit[1]) ? CH_ON : CH_OFF;
      blue   <= (vis && hit[2]) ? CH_ON : CH_OFF;
    end
  end
endmodule

// File: rtl/bounce_squares.sv
module bounce_squares
  import sq_pkg::*;
#(
  parameter int          CW    = 10,
  parameter int          H_RES = 640,
  parameter int          V_RES = 480,
  parameter int unsigned SQ_SIZE [NSQ] = '{32, 48, 40},
  parameter int unsigned SQ_SPX  [NSQ] = '{4, 3, 5},
  parameter int unsigned SQ_SPY  [NSQ] = '{2, 5, 3},
  parameter int unsigned SQ_X0   [NSQ] = '{100, 300, 500},
  parameter int unsigned SQ_Y0   [NSQ] = '{80, 200, 350},
  parameter bit          SQ_DX0  [NSQ] = '{1'b0, 1'b1, 1'b0},
  parameter bit          SQ_DY0  [NSQ] = '{1'b0, 1'b0, 1'b1}
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] sx,
  input  logic [CW-1:0] sy,
  input  logic          vis,
  input  logic          hs_in,
  input  logic          vs_in,
  output logic          hs_out,
  output logic          vs_out,
  output logic [3:0]    red,
  output logic [3:0]    green,
  output logic [3:0]    blue
);
  logic                tick;
  logic [NSQ*CW-1:0]   xpos_flat;
  logic [NSQ*CW-1:0]   ypos_flat;
  logic [NSQ-1:0]      hit;

  sq_tick #(.CW(CW), .V_RES(V_RES)) tick_i (
    .sx(sx), .sy(sy), .tick(tick)
  );

  for (genvar i = 0; i < NSQ; i++) begin : g_sq
    logic [CW-1:0] qx, qy;
    logic          hdir, vdir;

    sq_axis #(
      .CW(CW), .RES(H_RES), .SIZE(int'(SQ_SIZE[i])), .STEP(int'(SQ_SPX[i])),
      .START(int'(SQ_X0[i])), .DIR0(SQ_DX0[i])
    ) hx_i (
      .clk(clk), .rst(rst), .tick(tick), .pos(qx), .dir(hdir)
    );

    sq_axis #(
      .CW(CW), .RES(V_RES), .SIZE(int'(SQ_SIZE[i])), .STEP(int'(SQ_SPY[i])),
      .START(int'(SQ_Y0[i])), .DIR0(SQ_DY0[i])
    ) vy_i (
      .clk(clk), .rst(rst), .tick(tick), .pos(qy), .dir(vdir)
    );

    sq_cover #(.CW(CW), .SIZE(int'(SQ_SIZE[i]))) cov_i (
      .sx(sx), .sy(sy), .qx(qx), .qy(qy), .hit(hit[i])
    );

    assign xpos_flat[i*CW +: CW] = qx;
    assign ypos_flat[i*CW +: CW] = qy;
  end

  sq_out out_i (
    .clk(clk), .rst(rst), .vis(vis), .hs_in(hs_in), .vs_in(vs_in),
    .hit(hit), .hs_out(hs_out), .vs_out(vs_out),
    .red(red), .green(green), .blue(blue)
  );
endmodule

// File: rtl/bounce_squares_chk.sv
module bounce_squares_chk #(
  parameter int CW    = 10,
  parameter int NSQ   = 3,
  parameter int H_RES = 640,
  parameter int V_RES = 480
) (
  input logic              clk,
  input logic              rst,
  input logic              vis,
  input logic              hs_in,
  input logic              vs_in,
  input logic              hs_out,
  input logic              vs_out,
  input logic [3:0]        red,
  input logic [3:0]        green,
  input logic [3:0]        blue,
  input logic              tick,
  input logic [NSQ*CW-1:0] xpos_flat,
  input logic [NSQ*CW-1:0] ypos_flat
);
  logic seen;
  always_ff @(posedge clk) begin
    if (rst) seen <= 1'b0;
    else     seen <= 1'b1;
  end

  p_reset_idle_r1: assert property (@(posedge clk)
    $past(rst) |-> (red == 4'h0 && green == 4'h0 && blue == 4'h0 && hs_out && vs_out));

  p_blank_black_r9: assert property (@(posedge clk) disable iff (rst)
    seen && !$past(vis) |-> (red == 4'h0 && green == 4'h0 && blue == 4'h0));

  p_sync_delay_r10: assert property (@(posedge clk) disable iff (rst)
    seen |-> (hs_out == $past(hs_in) && vs_out == $past(vs_in)));

  p_hold_between_ticks_r2: assert property (@(posedge clk) disable iff (rst)
    seen && !$past(tick) |-> ($stable(xpos_flat) && $stable(ypos_flat)));

  for (genvar i = 0; i < NSQ; i++) begin : g_chk
    p_moves_on_tick_r5: assert property (@(posedge clk) disable iff (rst)
      seen && $past(tick) |-> !$stable(xpos_flat[i*CW +: CW]));
    p_x_inside_r3: assert property (@(posedge clk) disable iff (rst)
      seen |-> xpos_flat[i*CW +: CW] < CW'(H_RES));
    p_y_inside_r6: assert property (@(posedge clk) disable iff (rst)
      seen |-> ypos_flat[i*CW +: CW] < CW'(V_RES));
  end
endmodule

bind bounce_squares bounce_squares_chk #(
  .CW(CW), .NSQ(sq_pkg::NSQ), .H_RES(H_RES), .V_RES(V_RES)
) chk_i (
  .clk(clk), .rst(rst), .vis(vis), .hs_in(hs_in), .vs_in(vs_in),
  .hs_out(hs_out), .vs_out(vs_out), .red(red), .green(green), .blue(blue),
  .tick(tick), .xpos_flat(xpos_flat), .ypos_flat(ypos_flat)
);

// File: tb/bounce_squares_tb_top.sv
module bounce_squares_tb_top;
  localparam int CW = 10;
  localparam int HR = 640;
  localparam int VR = 480;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [CW-1:0] sx = '0, sy = '0;
  logic vis = 1'b0, hs_in = 1'b1, vs_in = 1'b1;
  logic hs_out, vs_out;
  logic [3:0] red, green, blue;

  always #2.5 clk = ~clk;

  bounce_squares #(
    .CW(CW), .H_RES(HR), .V_RES(VR),
    .SQ_SIZE('{32, 48, 40}), .SQ_SPX('{4, 3, 5}), .SQ_SPY('{2, 5, 3}),
    .SQ_X0('{100, 110, 120}), .SQ_Y0('{100, 110, 120}),
    .SQ_DX0('{1'b0, 1'b1, 1'b0}), .SQ_DY0('{1'b1, 1'b0, 1'b0})
  ) dut_i (
    .clk(clk), .rst(rst), .sx(sx), .sy(sy), .vis(vis),
    .hs_in(hs_in), .vs_in(vs_in), .hs_out(hs_out), .vs_out(vs_out),
    .red(red), .green(green), .blue(blue)
  );

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  int sz [3] = '{32, 48, 40};
  int spx[3] = '{4, 3, 5};
  int spy[3] = '{2, 5, 3};
  int px [3] = '{100, 110, 120};
  int py [3] = '{100, 110, 120};
  int dx [3] = '{0, 1, 0};
  int dy [3] = '{1, 0, 0};
  string ev[3];

  function automatic bit covers(int i, int x, int y);
    return (x >= px[i]) && (x < px[i] + sz[i]) && (y >= py[i]) && (y < py[i] + sz[i]);
  endfunction

  function automatic logic [11:0] exp_rgb(int x, int y, bit v);
    logic [11:0] c;
    c[11:8] = (v && covers(0, x, y)) ? 4'hF : 4'h0;
    c[7:4]  = (v && covers(1, x, y)) ? 4'hF : 4'h0;
    c[3:0]  = (v && covers(2, x, y)) ? 4'hF : 4'h0;
    return c;
  endfunction

  task automatic check(string tag, logic [11:0] act, logic [11:0] expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic probe(int x, int y, bit v, string tag);
    bit h, vv;
    h  = x[0];
    vv = y[1];
    sx = CW'(x); sy = CW'(y); vis = v; hs_in = h; vs_in = vv;
    @(negedge clk);
    check(tag, {red, green, blue}, exp_rgb(x, y, v));
    check("R10", {10'd0, hs_out, vs_out}, {10'd0, h, vv});
  endtask

  task automatic model_step();
    for (int i = 0; i < 3; i++) begin
      ev[i] = "R5";
      if (px[i] >= HR - (sz[i] + spx[i])) begin dx[i] = 1; px[i] -= spx[i]; ev[i] = "R3"; end
      else if (px[i] < spx[i]) begin dx[i] = 0; px[i] += spx[i]; ev[i] = "R4"; end
      else px[i] += (dx[i] != 0) ? -spx[i] : spx[i];
      if (py[i] >= VR - (sz[i] + spy[i])) begin dy[i] = 1; py[i] -= spy[i]; if (ev[i] == "R5") ev[i] = "R6"; end
      else if (py[i] < spy[i]) begin dy[i] = 0; py[i] += spy[i]; if (ev[i] == "R5") ev[i] = "R6"; end
      else py[i] += (dy[i] != 0) ? -spy[i] : spy[i];
    end
  endtask

  task automatic drive_tick();
    sx = '0; sy = CW'(VR); vis = 1'b0; hs_in = 1'b1; vs_in = 1'b1;
    @(negedge clk);
    model_step();
    check("R9", {red, green, blue}, 12'h000);
  endtask

  task automatic probe_square(int i, string tag);
    probe(px[i], py[i], 1'b1, tag);
    probe(px[i] + sz[i] - 1, py[i] + sz[i] - 1, 1'b1, tag);
    if (px[i] > 0) probe(px[i] - 1, py[i], 1'b1, "R7");
    if (px[i] + sz[i] < HR) probe(px[i] + sz[i], py[i] + sz[i] - 1, 1'b1, "R7");
    if (py[i] + sz[i] < VR) probe(px[i], py[i] + sz[i], 1'b1, "R7");
  endtask

  always @(posedge clk) begin
    if (!done && checks >= 0) begin
      if ($time > 150000 * 5) begin
        done = 1'b1;
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs held idle during reset
    check("R1", {red, green, blue}, 12'h000);
    check("R1", {10'd0, hs_out, vs_out}, 12'h003);
    rst = 1'b0;
    // R1 / R8: start corners, overlapping colour mixes
    probe(100, 100, 1'b1, "R1");
    probe(120, 120, 1'b1, "R8");
    probe(112, 112, 1'b1, "R8");
    probe(140, 140, 1'b1, "R8");
    probe(105, 105, 1'b1, "R8");
    probe(200, 200, 1'b1, "R8");
    probe(131, 131, 1'b1, "R7");
    probe(132, 100, 1'b1, "R7");
    probe(159, 159, 1'b1, "R7");
    probe(160, 159, 1'b1, "R7");
    // R9: blank region hides covered pixels
    probe(120, 120, 1'b0, "R9");
    // R2: near-miss coordinates do not move anything
    probe(1, 480, 1'b0, "R2");
    probe(0, 479, 1'b0, "R2");
    probe(0, 481, 1'b0, "R2");
    for (int i = 0; i < 3; i++) probe_square(i, "R2");
    // R3..R6: many frames so every square meets all borders
    for (int f = 0; f < 700; f++) begin
      drive_tick();
      for (int i = 0; i < 3; i++) probe_square(i, ev[i]);
      if (f % 50 == 0) probe(px[1], py[1], 1'b0, "R9");
    end
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule